// File: doc/BRIEF.md
# Invalidation Queue with Barrier Fencing

This block sits between a coherence interconnect and one core's cache tags. Incoming line invalidations are accepted on a valid/ready stream and acknowledged at once, so the remote requester does not wait for the tag update. The stored invalidations are then replayed, oldest first, on a valid/ready stream toward the tag array. While an invalidation is queued but not yet applied, the local cache may still hold a stale copy of that line.

The core sends barrier commands of three kinds: read, write and full. A read or full barrier fences the queue. Every entry present in that cycle gets a mark, and loads on the core's request/grant interface are held back until no marked entry is left. A write or full barrier raises a request toward the store buffer. A read or full barrier also raises a store-buffer snoop request. In addition, a load is held while its line address is still waiting in the queue.

A build parameter selects a flush strategy for simple in-order cores. In that mode a fencing barrier invalidates the whole cache in one pulse and empties the queue, instead of marking entries.

Back-pressure rules: an invalidation transfers in a cycle where `inv_valid` and `inv_ready` are both high. `inv_ready` is low only when the queue is full, or during a flush cycle. On the drain side `tag_valid` is held high and `tag_addr` held stable until `tag_ready` takes the entry.

Top module: `invq_fence`

## Requirements
- R1: An invalidation is taken when `inv_valid` and `inv_ready` are both high, and `inv_ack` is high in exactly that cycle. `inv_ready` is low while the queue holds DEPTH entries, even in a cycle where an entry drains.
- R2: `tag_valid` is high whenever the queue is non-empty, and `tag_addr` shows the oldest entry. One entry is removed per cycle with `tag_ready` high. While `tag_ready` is low, the head and its address hold.
- R3: `bar_kind` is decoded only while `bar_valid` is high: 2'b01 is read, 2'b10 is write, 2'b11 is full and 2'b00 has no effect. `sb_snoop` is high in the same cycle for read and full. `sb_mark` is high in the same cycle for write and full.
- R4: A read or full barrier marks every entry held in its cycle. An entry accepted in that cycle or later is not marked. `mark_pending` is high from the next cycle until the last marked entry has drained.
- R5: `ld_gnt` follows `ld_req` unless the load is stalled. A load is stalled while `mark_pending` is high. It is also stalled in the cycle of a read or full barrier when the queue is non-empty.
- R6: A write barrier marks no entry and does not stall loads.
- R7: A barrier that comes while marks are outstanding adds marks to every entry then held. The stall ends only when no marked entry remains.
- R8: A load whose `ld_addr` equals a queued entry's address is not granted, even with no barrier outstanding.
- R9: With FLUSH_MODE=1, a read or full barrier pulses `tag_flush_all` in its own cycle. In that cycle `inv_ready` is low and the queue is emptied at the clock edge, and `mark_pending` never rises. A write barrier does not flush. With FLUSH_MODE=0, `tag_flush_all` stays low.
- R10: After reset the queue is empty: `tag_valid` is 0, `inv_ready` is 1 and `mark_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Invalidation request valid |
| inv_ready | output | 1 | Queue can take an invalidation |
| inv_addr | input | ADDR_W | Line address to invalidate |
| inv_ack | output | 1 | Acknowledge of the accepted invalidation |
| tag_valid | output | 1 | Oldest entry presented to the tag port |
| tag_ready | input | 1 | Tag port applies the presented entry |
| tag_addr | output | ADDR_W | Line address of the oldest entry |
| tag_flush_all | output | 1 | Whole-cache invalidate pulse (flush mode) |
| bar_valid | input | 1 | Barrier command strobe |
| bar_kind | input | 2 | Barrier kind: 01 read, 10 write, 11 full |
| sb_mark | output | 1 | Store-buffer mark request |
| sb_snoop | output | 1 | Store-buffer snoop request |
| ld_req | input | 1 | Core load request |
| ld_addr | input | ADDR_W | Line address of the load |
| ld_gnt | output | 1 | Load may proceed this cycle |
| mark_pending | output | 1 | Marked entries are still waiting |

## Verification
`inv_ready`, `inv_ack`, `ld_gnt`, `sb_mark`, `sb_snoop` and `tag_flush_all` respond within the same cycle as the inputs that cause them. `mark_pending` and the head shown on `tag_valid`/`tag_addr` reflect a barrier, push or drain one rising edge later. The bench drives every input at the falling edge and reads outputs 1 ns later. Each table row therefore checks the same-cycle responses to its own stimulus, and also the registered state left by the row before it.

// File: rtl/invq_pkg.sv
package invq_pkg;

  typedef enum logic [1:0] {
    BAR_NONE  = 2'b00,
    BAR_READ  = 2'b01,
    BAR_WRITE = 2'b10,
    BAR_FULL  = 2'b11
  } bar_kind_e;

  // bit 0 selects the invalidation-queue side, bit 1 the store-buffer side
  function automatic logic fences_queue(bar_kind_e k);
    return k[0];
  endfunction

  function automatic logic fences_stores(bar_kind_e k);
    return k[1];
  endfunction

endpackage

// File: rtl/invq_store.sv
module invq_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  input  logic              mark_all,
  input  logic              clear_all,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] head_addr,
  output logic              marked_any,
  output logic              probe_hit
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [DEPTH-1:0]  vld, mrk, hit_vec;
  logic [ADDR_W-1:0] addr_q [DEPTH];

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // pointers and occupancy
  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // per-entry valid and mark bits
  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) begin
      vld <= '0;
      mrk <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && wr_ptr == PTR_W'(i)) begin
          vld[i] <= 1'b1;
          mrk[i] <= 1'b0;
        end else if (pop && rd_ptr == PTR_W'(i)) begin
          vld[i] <= 1'b0;
          mrk[i] <= 1'b0;
        end else if (mark_all && vld[i]) begin
          mrk[i] <= 1'b1;
        end
      end
    end
  end

  // address storage, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && wr_ptr == PTR_W'(i)) addr_q[i] <= push_addr;
    end
  end

  // parallel compare of the load address against every live entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_probe
    assign hit_vec[g] = vld[g] && (addr_q[g] == probe_addr);
  end

  assign probe_hit  = |hit_vec;
  assign marked_any = |mrk;
  assign full       = (count == CNT_W'(DEPTH));
  assign empty      = (count == '0);
  assign head_addr  = addr_q[rd_ptr];

endmodule

// File: rtl/invq_gate.sv
module invq_gate
  import invq_pkg::*;
#(
  parameter int FLUSH_MODE = 0
) (
  input  logic       bar_valid,
  input  logic [1:0] bar_kind,
  input  logic       occupied,
  input  logic       marked_any,
  input  logic       addr_hit,
  input  logic       ld_req,
  output logic       mark_all,
  output logic       flush_all,
  output logic       sb_mark,
  output logic       sb_snoop,
  output logic       ld_gnt
);

  bar_kind_e kind;
  logic      q_fence;
  logic      stall;

  assign kind    = bar_kind_e'(bar_kind);
  assign q_fence = bar_valid && fences_queue(kind);

  if (FLUSH_MODE != 0) begin : g_flush
    assign mark_all  = 1'b0;
    assign flush_all = q_fence;
  end else begin : g_mark
    assign mark_all  = q_fence;
    assign flush_all = 1'b0;
  end

  assign sb_snoop = q_fence;
  assign sb_mark  = bar_valid && fences_stores(kind);

  // a load in the barrier cycle counts as issued after the barrier
  assign stall  = marked_any || (q_fence && occupied) || addr_hit;
  assign ld_gnt = ld_req && !stall;

endmodule

// File: rtl/invq_fence.sv
module invq_fence #(
  parameter int DEPTH      = 4,
  parameter int ADDR_W     = 16,
  parameter int FLUSH_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_valid,
  output logic              inv_ready,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              inv_ack,
  output logic              tag_valid,
  input  logic              tag_ready,
  output logic [ADDR_W-1:0] tag_addr,
  output logic              tag_flush_all,
  input  logic              bar_valid,
  input  logic [1:0]        bar_kind,
  output logic              sb_mark,
  output logic              sb_snoop,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_gnt,
  output logic              mark_pending
);

  logic full, empty, marked_any, addr_hit;
  logic mark_all, flush_all, push, pop;

  assign inv_ready     = !full && !flush_all;
  assign push          = inv_valid && inv_ready;
  assign inv_ack       = push;
  assign tag_valid     = !empty;
  assign pop           = tag_valid && tag_ready;
  assign tag_flush_all = flush_all;
  assign mark_pending  = marked_any;

  invq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_addr  (inv_addr),
    .pop        (pop),
    .mark_all   (mark_all),
    .clear_all  (flush_all),
    .probe_addr (ld_addr),
    .full       (full),
    .empty      (empty),
    .head_addr  (tag_addr),
    .marked_any (marked_any),
    .probe_hit  (addr_hit)
  );

  invq_gate #(.FLUSH_MODE(FLUSH_MODE)) u_gate (
    .bar_valid  (bar_valid),
    .bar_kind   (bar_kind),
    .occupied   (!empty),
    .marked_any (marked_any),
    .addr_hit   (addr_hit),
    .ld_req     (ld_req),
    .mark_all   (mark_all),
    .flush_all  (flush_all),
    .sb_mark    (sb_mark),
    .sb_snoop   (sb_snoop),
    .ld_gnt     (ld_gnt)
  );

endmodule

// File: rtl/invq_chk.sv
module invq_chk #(
  parameter int FLUSH_MODE = 0,
  parameter int ADDR_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inv_ready,
  input logic              tag_valid,
  input logic              tag_ready,
  input logic [ADDR_W-1:0] tag_addr,
  input logic              tag_flush_all,
  input logic              bar_valid,
  input logic [1:0]        bar_kind,
  input logic              ld_gnt,
  input logic              mark_pending
);

  // R5
  fence_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_pending |-> !ld_gnt);

  // R4
  mark_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (FLUSH_MODE == 0 && bar_valid && bar_kind[0] && tag_valid && !tag_ready)
      |=> mark_pending);

  // R6
  write_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_valid && bar_kind == 2'b10 && !mark_pending) |=> !mark_pending);

  // R2
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_ready && !tag_flush_all) |=> (tag_valid && $stable(tag_addr)));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_flush_all |=> (!tag_valid && !mark_pending));

  // R1
  busy_means_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_ready && !tag_flush_all) |-> tag_valid);

endmodule

bind invq_fence invq_chk #(.FLUSH_MODE(FLUSH_MODE), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .inv_ready     (inv_ready),
  .tag_valid     (tag_valid),
  .tag_ready     (tag_ready),
  .tag_addr      (tag_addr),
  .tag_flush_all (tag_flush_all),
  .bar_valid     (bar_valid),
  .bar_kind      (bar_kind),
  .ld_gnt        (ld_gnt),
  .mark_pending  (mark_pending)
);

// File: tb/sim_invq_fence.sv
`timescale 1ns/1ps
module sim_invq_fence;

  localparam int AW = 16;
  localparam int NV = 16;
  // row: inv_v, inv_a, tag_r, bar, ld_r, ld_a | ir, tv, ta, gnt, mp, sbm, sbs
  localparam logic [58:0] VECS [NV] = '{
    {1'b1,16'h0011,1'b0,2'b00,1'b1,16'h0011, 1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0},
    {1'b1,16'h0022,1'b0,2'b00,1'b1,16'h0011, 1'b1,1'b1,16'h0011,1'b0,1'b0,1'b0,1'b0},
    {1'b1,16'h0033,1'b0,2'b00,1'b1,16'h0044, 1'b1,1'b1,16'h0011,1'b1,1'b0,1'b0,1'b0},
    {1'b1,16'h0044,1'b0,2'b01,1'b1,16'h0055, 1'b1,1'b1,16'h0011,1'b0,1'b0,1'b0,1'b1},
    {1'b0,16'h0000,1'b0,2'b00,1'b1,16'h0055, 1'b0,1'b1,16'h0011,1'b0,1'b1,1'b0,1'b0},
    {1'b1,16'h0066,1'b1,2'b00,1'b1,16'h0055, 1'b0,1'b1,16'h0011,1'b0,1'b1,1'b0,1'b0},
    {1'b1,16'h0066,1'b1,2'b00,1'b1,16'h0055, 1'b1,1'b1,16'h0022,1'b0,1'b1,1'b0,1'b0},
    {1'b0,16'h0000,1'b1,2'b10,1'b1,16'h0055, 1'b1,1'b1,16'h0033,1'b0,1'b1,1'b1,1'b0},
    {1'b0,16'h0000,1'b0,2'b00,1'b1,16'h0055, 1'b1,1'b1,16'h0044,1'b1,1'b0,1'b0,1'b0},
    {1'b0,16'h0000,1'b0,2'b11,1'b1,16'h0077, 1'b1,1'b1,16'h0044,1'b0,1'b0,1'b1,1'b1},
    {1'b1,16'h0088,1'b1,2'b00,1'b1,16'h0077, 1'b1,1'b1,16'h0044,1'b0,1'b1,1'b0,1'b0},
    {1'b0,16'h0000,1'b0,2'b01,1'b1,16'h0077, 1'b1,1'b1,16'h0066,1'b0,1'b1,1'b0,1'b1},
    {1'b0,16'h0000,1'b1,2'b00,1'b1,16'h0077, 1'b1,1'b1,16'h0066,1'b0,1'b1,1'b0,1'b0},
    {1'b0,16'h0000,1'b0,2'b00,1'b1,16'h0077, 1'b1,1'b1,16'h0088,1'b0,1'b1,1'b0,1'b0},
    {1'b0,16'h0000,1'b1,2'b00,1'b1,16'h0088, 1'b1,1'b1,16'h0088,1'b0,1'b1,1'b0,1'b0},
    {1'b0,16'h0000,1'b0,2'b00,1'b1,16'h0088, 1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  // marking instance
  logic          inv_valid, inv_ready, inv_ack, tag_valid, tag_ready, tag_flush_all;
  logic [AW-1:0] inv_addr, tag_addr, ld_addr;
  logic          bar_valid, sb_mark, sb_snoop, ld_req, ld_gnt, mark_pending;
  logic [1:0]    bar_kind;

  // flushing instance
  logic          f_inv_valid, f_inv_ready, f_inv_ack, f_tag_valid, f_tag_ready, f_flush;
  logic [AW-1:0] f_inv_addr, f_tag_addr, f_ld_addr;
  logic          f_bar_valid, f_sb_mark, f_sb_snoop, f_ld_req, f_ld_gnt, f_mp;
  logic [1:0]    f_bar_kind;

  invq_fence #(.DEPTH(4), .ADDR_W(AW), .FLUSH_MODE(0)) u0 (
    .clk(clk), .rst_n(rst_n),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_addr(inv_addr), .inv_ack(inv_ack),
    .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_addr(tag_addr),
    .tag_flush_all(tag_flush_all),
    .bar_valid(bar_valid), .bar_kind(bar_kind), .sb_mark(sb_mark), .sb_snoop(sb_snoop),
    .ld_req(ld_req), .ld_addr(ld_addr), .ld_gnt(ld_gnt), .mark_pending(mark_pending)
  );

  invq_fence #(.DEPTH(4), .ADDR_W(AW), .FLUSH_MODE(1)) u1 (
    .clk(clk), .rst_n(rst_n),
    .inv_valid(f_inv_valid), .inv_ready(f_inv_ready), .inv_addr(f_inv_addr), .inv_ack(f_inv_ack),
    .tag_valid(f_tag_valid), .tag_ready(f_tag_ready), .tag_addr(f_tag_addr),
    .tag_flush_all(f_flush),
    .bar_valid(f_bar_valid), .bar_kind(f_bar_kind), .sb_mark(f_sb_mark), .sb_snoop(f_sb_snoop),
    .ld_req(f_ld_req), .ld_addr(f_ld_addr), .ld_gnt(f_ld_gnt), .mark_pending(f_mp)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    inv_valid = 0; inv_addr = '0; tag_ready = 0; bar_valid = 0; bar_kind = 2'b00;
    ld_req = 0; ld_addr = '0;
    f_inv_valid = 0; f_inv_addr = '0; f_tag_ready = 0; f_bar_valid = 0; f_bar_kind = 2'b00;
    f_ld_req = 0; f_ld_addr = '0;
    repeat (3) @(posedge clk);
    settle();
    rst_n = 1'b1;
    #1;
    chk("R10", "tag_valid", AW'(tag_valid), AW'(0));
    chk("R10", "inv_ready", AW'(inv_ready), AW'(1));
    chk("R10", "mark_pending", AW'(mark_pending), AW'(0));
    chk("R10", "flush tag_valid", AW'(f_tag_valid), AW'(0));

    // table walk on the marking instance
    for (int v = 0; v < NV; v++) begin
      settle();
      inv_valid = VECS[v][58];
      inv_addr  = VECS[v][57:42];
      tag_ready = VECS[v][41];
      bar_kind  = VECS[v][40:39];
      bar_valid = (VECS[v][40:39] != 2'b00);
      ld_req    = VECS[v][38];
      ld_addr   = VECS[v][37:22];
      #1;
      chk("R1", $sformatf("row %0d inv_ready", v), AW'(inv_ready), AW'(VECS[v][21]));
      chk("R1", $sformatf("row %0d inv_ack", v), AW'(inv_ack), AW'(VECS[v][21] & VECS[v][58]));
      chk("R2", $sformatf("row %0d tag_valid", v), AW'(tag_valid), AW'(VECS[v][20]));
      if (VECS[v][20])
        chk("R2", $sformatf("row %0d tag_addr", v), tag_addr, VECS[v][19:4]);
      chk("R5", $sformatf("row %0d ld_gnt", v), AW'(ld_gnt), AW'(VECS[v][3]));
      chk("R4/R7", $sformatf("row %0d mark_pending", v), AW'(mark_pending), AW'(VECS[v][2]));
      chk("R3", $sformatf("row %0d sb_mark", v), AW'(sb_mark), AW'(VECS[v][1]));
      chk("R3", $sformatf("row %0d sb_snoop", v), AW'(sb_snoop), AW'(VECS[v][0]));
      chk("R9", $sformatf("row %0d tag_flush_all", v), AW'(tag_flush_all), AW'(0));
    end

    // kind 00 with the strobe high does nothing
    settle();
    inv_valid = 1; inv_addr = 16'h0101; tag_ready = 0; bar_valid = 0; ld_req = 0;
    settle();
    inv_valid = 0; bar_valid = 1; bar_kind = 2'b00; ld_req = 1; ld_addr = 16'h0202;
    #1;
    chk("R3", "kind 00 sb_mark", AW'(sb_mark), AW'(0));
    chk("R3", "kind 00 sb_snoop", AW'(sb_snoop), AW'(0));
    chk("R3", "kind 00 ld_gnt", AW'(ld_gnt), AW'(1));
    settle();
    bar_valid = 0;
    #1;
    chk("R3", "kind 00 mark_pending", AW'(mark_pending), AW'(0));
    // load to a queued line
    ld_addr = 16'h0101;
    #1;
    chk("R8", "hit ld_gnt", AW'(ld_gnt), AW'(0));
    ld_addr = 16'h0203;
    #1;
    chk("R8", "miss ld_gnt", AW'(ld_gnt), AW'(1));
    // write barrier with a queued entry
    bar_valid = 1; bar_kind = 2'b10;
    #1;
    chk("R6", "write bar ld_gnt", AW'(ld_gnt), AW'(1));
    chk("R6", "write bar sb_mark", AW'(sb_mark), AW'(1));
    settle();
    bar_valid = 0;
    #1;
    chk("R6", "write bar mark_pending", AW'(mark_pending), AW'(0));
    chk("R6", "write bar ld_gnt after", AW'(ld_gnt), AW'(1));
    tag_ready = 1;
    settle();
    tag_ready = 0; ld_req = 0;
    #1;
    chk("R2", "drained tag_valid", AW'(tag_valid), AW'(0));

    // flushing instance
    f_inv_valid = 1; f_inv_addr = 16'h0A01;
    settle();
    f_inv_addr = 16'h0A02;
    settle();
    f_inv_addr = 16'h0A03; f_bar_valid = 1; f_bar_kind = 2'b01;
    f_ld_req = 1; f_ld_addr = 16'h0B00;
    #1;
    chk("R9", "flush pulse", AW'(f_flush), AW'(1));
    chk("R9", "flush inv_ready", AW'(f_inv_ready), AW'(0));
    chk("R9", "flush inv_ack", AW'(f_inv_ack), AW'(0));
    chk("R9", "flush ld_gnt", AW'(f_ld_gnt), AW'(0));
    settle();
    f_inv_valid = 0; f_bar_valid = 0;
    #1;
    chk("R9", "after flush tag_valid", AW'(f_tag_valid), AW'(0));
    chk("R9", "after flush mark_pending", AW'(f_mp), AW'(0));
    chk("R9", "after flush ld_gnt", AW'(f_ld_gnt), AW'(1));
    chk("R9", "after flush pulse", AW'(f_flush), AW'(0));
    f_inv_valid = 1; f_inv_addr = 16'h0A04;
    settle();
    f_inv_valid = 0; f_bar_valid = 1; f_bar_kind = 2'b10;
    #1;
    chk("R9", "write bar no flush", AW'(f_flush), AW'(0));
    settle();
    f_bar_valid = 0;
    #1;
    chk("R9", "write bar keeps entry", AW'(f_tag_valid), AW'(1));
    chk("R9", "write bar entry addr", f_tag_addr, 16'h0A04);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule